// File: doc/BRIEF.md
# Two-Level Breakpoint Status Tracker

This block keeps the arming and firing state of a chained pair of hardware breakpoints. A configuration write arms the first level, and can also mark the second level as enabled. When the second level is enabled, a first-level match does not end the sequence. Instead it arms the second level, and only a second-level match completes the chain. The state is exposed in two forms. The first is a 4-bit status code that software reads. The second is a 4-bit nibble that the debug trace port broadcasts.

A read of the status clears it once the final enabled level has fired. In every other state the read leaves the status alone. A write to either of the trigger definition registers drops the status back to the idle code at once. The comparators that raise the match pulses, the register file and the trace serializer all sit outside this block.

Top module: `bkpt_status_tracker`

## Requirements
- R1: After reset, `status` is 0000 and `trace_nib` is 0000.
- R2: A `cfg_wr` pulse loads the status on the next clock edge. The new status is 0001 if `cfg_l1_en` is 1 and 0000 if it is 0. The same pulse latches `cfg_l2_en` as the level-2 enable.
- R3: In status 0001 with level 2 disabled, an `l1_hit` pulse moves the status to 0010.
- R4: In status 0001 with level 2 enabled, an `l1_hit` pulse moves the status to 0101. In status 0101, an `l2_hit` pulse moves it to 0110.
- R5: An `l2_hit` pulse while the status is 0001 is ignored, and the status stays 0001.
- R6: A `stat_rd` pulse clears the status to 0000 when the status is 0110. It also clears the status when the status is 0010 and level 2 is disabled.
- R7: A `stat_rd` pulse while the status is 0001 or 0101 leaves the status unchanged.
- R8: A pulse on any bit of `trig_wr` clears the status to 0000 on the next edge, from any state. This clear takes priority over every other input in the same cycle.
- R9: `trace_nib` is registered and lags `status` by one cycle. It encodes 0000→0000, 0001→0010, 0010→0100, 0101→1010 and 0110→1100, and it never shows any other code.
- R10: A `cfg_wr` pulse takes priority over `stat_rd`, `l1_hit` and `l2_hit` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_l1_en | input | 1 | Level-1 enable, sampled with `cfg_wr` |
| cfg_l2_en | input | 1 | Level-2 enable, sampled with `cfg_wr` |
| l1_hit | input | 1 | Level-1 match pulse |
| l2_hit | input | 1 | Level-2 match pulse |
| stat_rd | input | 1 | Status-register read strobe |
| trig_wr | input | TRIG_REGS | One write strobe per trigger definition register |
| status | output | 4 | Current status code |
| trace_nib | output | 4 | Registered trace nibble |

## Verification
The assertions assume that every input is a known value on every clock edge after reset. They also assume that the enable bits matter only in a cycle where `cfg_wr` is high. The transition properties check only cycles in which no higher-priority event (a trigger write or a configuration write) is present. The stimulus changes inputs only on falling edges and holds every strobe low unless a step names it. Any combination of strobes in a cycle is legal, so the bench also drives colliding strobes to exercise the priority order.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    BS_OFF  = 4'b0000,
    BS_ARM1 = 4'b0001,
    BS_HIT1 = 4'b0010,
    BS_ARM2 = 4'b0101,
    BS_HIT2 = 4'b0110
  } bstat_e;

  // Trace code broadcast for each status
  function automatic logic [CODE_W-1:0] trace_code(bstat_e s);
    case (s)
      BS_ARM1: trace_code = 4'b0010;
      BS_HIT1: trace_code = 4'b0100;
      BS_ARM2: trace_code = 4'b1010;
      BS_HIT2: trace_code = 4'b1100;
      default: trace_code = 4'b0000;
    endcase
  endfunction

  // True when the last enabled level has fired, so a read may clear
  function automatic logic chain_done(bstat_e s, logic l2_en);
    chain_done = (s == BS_HIT2) || ((s == BS_HIT1) && !l2_en);
  endfunction
endpackage

// File: rtl/bkpt_arm_ctrl.sv
module bkpt_arm_ctrl #(
  parameter int unsigned TRIG_REGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_l2_en,
  input  logic [TRIG_REGS-1:0] trig_wr,
  output logic                 clear_req,
  output logic                 l2_en
);
  logic [TRIG_REGS-1:0] trig_any;

  // OR-reduce the trigger strobes as a chain
  generate
    for (genvar i = 0; i < TRIG_REGS; i++) begin : g_trig
      if (i == 0) begin : g_first
        assign trig_any[i] = trig_wr[i];
      end else begin : g_rest
        assign trig_any[i] = trig_any[i-1] | trig_wr[i];
      end
    end
  endgenerate

  assign clear_req = trig_any[TRIG_REGS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      l2_en <= 1'b0;
    else if (cfg_wr) l2_en <= cfg_l2_en;
  end

  // R2: the level-2 enable follows the configuration write
  p_l2_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (l2_en == $past(cfg_l2_en)));
  p_l2_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(l2_en));
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear_req,
  input  logic   cfg_wr,
  input  logic   cfg_l1_en,
  input  logic   l2_en,
  input  logic   l1_hit,
  input  logic   l2_hit,
  input  logic   stat_rd,
  output bstat_e status
);
  bstat_e st_q, st_d;
  logic   quiet;
  logic   l1_fire;
  logic   l2_fire;
  logic   rd_clear_ok;

  assign quiet       = !clear_req && !cfg_wr;
  assign l1_fire     = quiet && (st_q == BS_ARM1) && l1_hit;
  assign l2_fire     = quiet && (st_q == BS_ARM2) && l2_hit;
  assign rd_clear_ok = quiet && stat_rd && chain_done(st_q, l2_en);

  always_comb begin
    st_d = st_q;
    if (clear_req)        st_d = BS_OFF;
    else if (cfg_wr)      st_d = cfg_l1_en ? BS_ARM1 : BS_OFF;
    else if (rd_clear_ok) st_d = BS_OFF;
    else if (l1_fire)     st_d = l2_en ? BS_ARM2 : BS_HIT1;
    else if (l2_fire)     st_d = BS_HIT2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BS_OFF;
    else        st_q <= st_d;
  end

  assign status = st_q;

  // R8: a trigger write always lands on idle
  p_trig_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (status == BS_OFF));
  // R2 / R10: a configuration write overrides reads and matches
  p_cfg_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_req && cfg_wr) |=> (status == ($past(cfg_l1_en) ? BS_ARM1 : BS_OFF)));
  // R3
  p_l1_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && status == BS_ARM1 && l1_hit && !l2_en) |=> (status == BS_HIT1));
  // R4
  p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && status == BS_ARM1 && l1_hit && l2_en) |=> (status == BS_ARM2));
  p_l2_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && status == BS_ARM2 && l2_hit) |=> (status == BS_HIT2));
  // R5
  p_l2_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && status == BS_ARM1 && l2_hit && !l1_hit) |=> (status == BS_ARM1));
  // R6
  p_rd_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && stat_rd && status == BS_HIT2) |=> (status == BS_OFF));
  // R7
  p_rd_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && stat_rd && !l1_hit && !l2_hit &&
     (status == BS_ARM1 || status == BS_ARM2)) |=> $stable(status));
endmodule

// File: rtl/bkpt_trace_enc.sv
module bkpt_trace_enc
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bstat_e            status,
  output logic [CODE_W-1:0] nib
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nib <= '0;
    else        nib <= trace_code(status);
  end

  // R9: one-cycle lag behind the status
  p_nib_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nib == trace_code($past(status))));
  // R9: only the five defined codes appear
  p_nib_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nib == 4'b0000) || (nib == 4'b0010) || (nib == 4'b0100) ||
    (nib == 4'b1010) || (nib == 4'b1100));
endmodule

// File: rtl/bkpt_status_tracker.sv
module bkpt_status_tracker
  import bkpt_pkg::*;
#(
  parameter int unsigned TRIG_REGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_l1_en,
  input  logic                 cfg_l2_en,
  input  logic                 l1_hit,
  input  logic                 l2_hit,
  input  logic                 stat_rd,
  input  logic [TRIG_REGS-1:0] trig_wr,
  output logic [3:0]           status,
  output logic [3:0]           trace_nib
);
  logic   clear_req;
  logic   l2_en;
  bstat_e st;

  bkpt_arm_ctrl #(.TRIG_REGS(TRIG_REGS)) u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_l2_en(cfg_l2_en),
    .trig_wr  (trig_wr),
    .clear_req(clear_req),
    .l2_en    (l2_en)
  );

  bkpt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_req(clear_req),
    .cfg_wr   (cfg_wr),
    .cfg_l1_en(cfg_l1_en),
    .l2_en    (l2_en),
    .l1_hit   (l1_hit),
    .l2_hit   (l2_hit),
    .stat_rd  (stat_rd),
    .status   (st)
  );

  bkpt_trace_enc u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .status(st),
    .nib   (trace_nib)
  );

  assign status = st;

  // R1: idle code straight out of reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (status == 4'b0000 && trace_nib == 4'b0000));
endmodule

// File: tb/bkpt_status_tracker_bench.sv
module bkpt_status_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_l1_en = 1'b0, cfg_l2_en = 1'b0;
  logic       l1_hit = 1'b0, l2_hit = 1'b0, stat_rd = 1'b0;
  logic [1:0] trig_wr = 2'b00;
  logic [3:0] status, trace_nib;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [3:0] st;
    logic [3:0] nb;
    string      tag;
  } exp_t;
  exp_t exq[$];

  logic [3:0] m_st = 4'h0;
  logic       m_l2 = 1'b0;

  always #4 clk = ~clk;

  bkpt_status_tracker u_bkpt_status_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_l1_en(cfg_l1_en),
    .cfg_l2_en(cfg_l2_en), .l1_hit(l1_hit), .l2_hit(l2_hit),
    .stat_rd(stat_rd), .trig_wr(trig_wr), .status(status),
    .trace_nib(trace_nib)
  );

  function automatic logic [3:0] nib_of(logic [3:0] s);
    logic [3:0] r;
    r = 4'h0;
    if (s == 4'h1) r = 4'h2;
    if (s == 4'h2) r = 4'h4;
    if (s == 4'h5) r = 4'hA;
    if (s == 4'h6) r = 4'hC;
    return r;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic cw, input logic e1, input logic e2,
                      input logic h1, input logic h2, input logic rd,
                      input logic [1:0] tw, input string tag);
    exp_t e;
    cfg_wr = cw; cfg_l1_en = e1; cfg_l2_en = e2;
    l1_hit = h1; l2_hit = h2; stat_rd = rd; trig_wr = tw;
    @(posedge clk);
    e.nb = nib_of(m_st);
    if (tw != 2'b00) m_st = 4'h0;
    else if (cw) begin m_l2 = e2; m_st = e1 ? 4'h1 : 4'h0; end
    else if (m_st == 4'h1 && h1) m_st = m_l2 ? 4'h5 : 4'h2;
    else if (m_st == 4'h5 && h2) m_st = 4'h6;
    else if (m_st == 4'h2 && rd && !m_l2) m_st = 4'h0;
    else if (m_st == 4'h6 && rd) m_st = 4'h0;
    e.st = m_st;
    e.tag = tag;
    exq.push_back(e);
    @(negedge clk);
    cfg_wr = 0; cfg_l1_en = 0; cfg_l2_en = 0;
    l1_hit = 0; l2_hit = 0; stat_rd = 0; trig_wr = 2'b00;
  endtask

  // Monitor: compares design outputs with the queued expectations
  always @(negedge clk) begin
    if (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      n_chk++;
      if (status !== e.st) begin
        n_bad++;
        $display("FAIL %s status: got %b expected %b", e.tag, status, e.st);
      end
      n_chk++;
      if (trace_nib !== e.nb) begin
        n_bad++;
        $display("FAIL R9 trace_nib (%s): got %b expected %b", e.tag, trace_nib, e.nb);
      end
    end
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (status !== 4'h0 || trace_nib !== 4'h0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b/%b expected 0000/0000", status, trace_nib);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0,0,0,0,0,0,2'b00, "R1 idle");
    step(1,1,0,0,0,0,2'b00, "R2 arm l1");
    step(0,0,0,0,1,0,2'b00, "R5 early l2");
    step(0,0,0,0,0,1,2'b00, "R7 read arm1");
    step(0,0,0,1,0,0,2'b00, "R3 l1 fires");
    step(0,0,0,0,0,0,2'b00, "R3 hold hit1");
    step(0,0,0,0,0,1,2'b00, "R6 read hit1");
    step(1,1,1,0,0,0,2'b00, "R2 arm both");
    step(0,0,0,1,0,0,2'b00, "R4 l1 to arm2");
    step(0,0,0,0,0,1,2'b00, "R7 read arm2");
    step(0,0,0,1,0,0,2'b00, "R4 l1 repeat");
    step(0,0,0,0,1,0,2'b00, "R4 l2 fires");
    step(0,0,0,0,0,0,2'b00, "R9 hold hit2");
    step(0,0,0,0,0,1,2'b00, "R6 read hit2");
    step(1,1,1,0,0,0,2'b00, "R2 rearm");
    step(0,0,0,1,0,0,2'b00, "R4 chain");
    step(0,0,0,0,1,0,2'b10, "R8 trig wins");
    step(1,1,0,0,0,0,2'b00, "R2 arm l1");
    step(0,0,0,0,0,0,2'b01, "R8 trig0 clear");
    step(1,1,1,0,0,0,2'b00, "R2 arm both");
    step(0,0,0,1,0,0,2'b00, "R4 chain");
    step(0,0,0,0,1,0,2'b00, "R4 hit2");
    step(1,1,0,1,1,1,2'b00, "R10 cfg wins");
    step(0,0,0,1,0,0,2'b00, "R3 l1 fires");
    step(1,0,0,0,0,1,2'b00, "R2 disarm");
    step(1,1,0,0,0,0,2'b11, "R8 over cfg");
    step(0,0,0,0,0,0,2'b00, "R9 drain");
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule